// File: doc/BRIEF.md
# Memory Refresh Read-Write Trigger

This block holds a 32-bit refresh address register on a simple register bus. A bus write to that register starts one refresh of a single on-chip memory word: the word is read, and the same data is written back to the same word. The memory port stays locked for the whole operation, so no other master can reach the word between the read and the write-back.

A pending flag is set while a refresh is in flight. Software reads this flag from a separate status register and waits until it is clear before writing a new address. A write to the address register while the flag is set is refused with a bus error and has no effect.

Only the lower half of the address register can be written. The upper half is fixed to the base of the on-chip memory region. The three lowest address bits are stored, but they play no part in selecting the 8-byte memory word.

Top module: `rmw_refresh_ctl`

## Requirements
- R1: A write to offset 0x0 while the pending flag is clear is accepted. In the next cycle `mem_rd_req` rises, with `mem_addr` equal to bits 31:3 of the updated register.
- R2: Bit 0 of the status register at offset 0x4 reads 1 from the cycle after an accepted write until the cycle after the write acknowledge. It reads 0 at all other times, and bits 31:1 always read 0.
- R3: A write to offset 0x0 while the flag is set is acknowledged with `reg_err`=1. The register value and `mem_addr` stay unchanged, and no new refresh starts.
- R4: Bus writes change only bits 15:0 of the address register. Bits 31:16 always read 0x2008.
- R5: Register bits 2:0 are stored and read back as written. `mem_addr` is always register bits 31:3, so the access goes to the 8-byte-aligned word.
- R6: After reset the address register reads 0x2008_0000, the status register reads 0, and `mem_lock`, `mem_rd_req` and `mem_wr_req` are low.
- R7: `mem_rd_req` is held until a cycle in which `mem_rd_valid` is high. In the following cycle `mem_wr_req` rises, carrying the read data on `mem_wdata`, and it is held until `mem_wr_ack`. The two requests are never high together.
- R8: `mem_lock` is high in every cycle in which a read or write request is high. It falls in the cycle after the write acknowledge.
- R9: Every bus request is acknowledged with `reg_ack` exactly one cycle later. Reads never raise `reg_err`, including reads made during a refresh. Writes to offset 0x4 or to unmapped offsets have no effect and raise no error. Reads of unmapped offsets return 0.
- R10: A write to offset 0x0 in the same cycle as `mem_wr_ack` is still refused with an error. The flag clears only after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_req | input | 1 | Bus request strobe, one cycle per access |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | REG_AW | Byte offset of the access |
| reg_wdata | input | ADDR_W | Write data |
| reg_ack | output | 1 | Access acknowledge, one cycle after request |
| reg_err | output | 1 | Bus error, valid with `reg_ack` |
| reg_rdata | output | ADDR_W | Read data, valid with `reg_ack`, 0 otherwise |
| mem_addr | output | ADDR_W-3 | Memory word index (register bits 31:3) |
| mem_lock | output | 1 | Memory port locked for the atomic operation |
| mem_rd_req | output | 1 | Memory read request |
| mem_rd_valid | input | 1 | Memory read data valid |
| mem_rd_data | input | MEM_DW | Memory read data |
| mem_wr_req | output | 1 | Memory write-back request |
| mem_wdata | output | MEM_DW | Write-back data |
| mem_wr_ack | input | 1 | Memory write acknowledge |

## Verification
The hardest case to reach is a register write that lands in exactly the cycle the write acknowledge returns. At that point the engine is about to go idle, but the write must still be refused. The stimulus reaches it by watching the memory responder's acknowledge strobe at half-cycle resolution and issuing the bus write in that same cycle, using a long write latency so the window can be hit on purpose. Rejected writes in the middle of a refresh, and zero-latency memory replies, are also driven, so that the lock and flag edges are compared against the reference model cycle by cycle.

// File: rtl/rfr_pkg.sv
package rfr_pkg;
  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_READ  = 2'd1,
    ENG_WRITE = 2'd2
  } eng_state_e;
endpackage

// File: rtl/rfr_regfile.sv
module rfr_regfile #(
  parameter int REG_AW = 4,
  parameter int ADDR_W = 32,
  parameter int LO_W   = 16,
  parameter logic [ADDR_W-1:0] RESET_VAL = 32'h2008_0000,
  parameter logic [REG_AW-1:0] AREG_OFF  = 'h0,
  parameter logic [REG_AW-1:0] STAT_OFF  = 'h4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [REG_AW-1:0] addr,
  input  logic [ADDR_W-1:0] wdata,
  input  logic              busy,
  output logic              ack,
  output logic              err,
  output logic [ADDR_W-1:0] rdata,
  output logic [ADDR_W-1:0] reg_value,
  output logic              wr_accept
);
  localparam int HI_W = ADDR_W - LO_W;
  localparam logic [HI_W-1:0] HI_FIXED = RESET_VAL[ADDR_W-1:LO_W];
  localparam logic [LO_W-1:0] LO_INIT  = RESET_VAL[LO_W-1:0];

  // full register image from the writable low half
  function automatic logic [ADDR_W-1:0] compose(input logic [LO_W-1:0] lo);
    return {HI_FIXED, lo};
  endfunction

  function automatic logic [ADDR_W-1:0] status_word(input logic flag);
    return {{(ADDR_W-1){1'b0}}, flag};
  endfunction

  logic [LO_W-1:0] lo_q;
  logic            hit_areg, hit_stat, wr_reject;
  logic            unused_hi;

  assign hit_areg  = (addr == AREG_OFF);
  assign hit_stat  = (addr == STAT_OFF);
  assign wr_accept = req && we && hit_areg && !busy;
  assign wr_reject = req && we && hit_areg && busy;
  assign reg_value = compose(lo_q);
  assign unused_hi = ^wdata[ADDR_W-1:LO_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= LO_INIT;
      ack   <= 1'b0;
      err   <= 1'b0;
      rdata <= '0;
    end else begin
      ack <= req;
      err <= wr_reject;
      if (wr_accept) lo_q <= wdata[LO_W-1:0];
      if (req && !we) begin
        if (hit_areg)      rdata <= compose(lo_q);
        else if (hit_stat) rdata <= status_word(busy);
        else               rdata <= '0;
      end else begin
        rdata <= '0;
      end
    end
  end
endmodule

// File: rtl/rfr_engine.sv
module rfr_engine
  import rfr_pkg::*;
#(
  parameter int MEM_AW = 29,
  parameter int MEM_DW = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [MEM_AW-1:0] word_idx,
  output logic [MEM_AW-1:0] mem_addr,
  output logic              mem_rd_req,
  input  logic              mem_rd_valid,
  input  logic [MEM_DW-1:0] mem_rd_data,
  output logic              mem_wr_req,
  output logic [MEM_DW-1:0] mem_wdata,
  input  logic              mem_wr_ack,
  output logic              mem_lock,
  output logic              busy,
  output logic              rd_done,
  output logic              wr_done
);
  eng_state_e      st_q;
  logic [MEM_DW-1:0] data_q;

  assign rd_done    = (st_q == ENG_READ)  && mem_rd_valid;
  assign wr_done    = (st_q == ENG_WRITE) && mem_wr_ack;
  assign mem_rd_req = (st_q == ENG_READ);
  assign mem_wr_req = (st_q == ENG_WRITE);
  assign busy       = (st_q != ENG_IDLE);
  assign mem_lock   = busy;
  assign mem_addr   = word_idx;
  assign mem_wdata  = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ENG_IDLE;
      data_q <= '0;
    end else begin
      unique case (st_q)
        ENG_IDLE:  if (start) st_q <= ENG_READ;
        ENG_READ:  if (rd_done) begin
                     data_q <= mem_rd_data;
                     st_q   <= ENG_WRITE;
                   end
        ENG_WRITE: if (wr_done) st_q <= ENG_IDLE;
        default:   st_q <= ENG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rmw_refresh_ctl.sv
module rmw_refresh_ctl #(
  parameter int REG_AW   = 4,
  parameter int ADDR_W   = 32,
  parameter int LO_W     = 16,
  parameter int ALIGN_W  = 3,
  parameter int MEM_DW   = 64,
  parameter logic [ADDR_W-1:0] RESET_VAL = 32'h2008_0000,
  localparam int MEM_AW  = ADDR_W - ALIGN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_req,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic              reg_ack,
  output logic              reg_err,
  output logic [ADDR_W-1:0] reg_rdata,
  output logic [MEM_AW-1:0] mem_addr,
  output logic              mem_lock,
  output logic              mem_rd_req,
  input  logic              mem_rd_valid,
  input  logic [MEM_DW-1:0] mem_rd_data,
  output logic              mem_wr_req,
  output logic [MEM_DW-1:0] mem_wdata,
  input  logic              mem_wr_ack
);
  // 8-byte alignment: drop the don't-care low bits
  function automatic logic [MEM_AW-1:0] word_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:ALIGN_W];
  endfunction

  logic [ADDR_W-1:0] reg_value;
  logic              wr_accept;
  logic              busy;
  logic              rd_done, wr_done;
  logic              unused_align;

  assign unused_align = ^reg_value[ALIGN_W-1:0];

  rfr_regfile #(
    .REG_AW(REG_AW), .ADDR_W(ADDR_W), .LO_W(LO_W), .RESET_VAL(RESET_VAL)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .req(reg_req), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .busy(busy),
    .ack(reg_ack), .err(reg_err), .rdata(reg_rdata),
    .reg_value(reg_value), .wr_accept(wr_accept)
  );

  rfr_engine #(.MEM_AW(MEM_AW), .MEM_DW(MEM_DW)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .start(wr_accept), .word_idx(word_of(reg_value)),
    .mem_addr(mem_addr),
    .mem_rd_req(mem_rd_req), .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .mem_wr_req(mem_wr_req), .mem_wdata(mem_wdata), .mem_wr_ack(mem_wr_ack),
    .mem_lock(mem_lock), .busy(busy),
    .rd_done(rd_done), .wr_done(wr_done)
  );
endmodule

// File: rtl/rfr_checks.sv
module rfr_checks #(
  parameter int REG_AW = 4,
  parameter int ADDR_W = 32,
  parameter int LO_W   = 16,
  parameter int MEM_AW = 29,
  parameter logic [ADDR_W-1:0] RESET_VAL = 32'h2008_0000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_req,
  input logic              reg_we,
  input logic [REG_AW-1:0] reg_addr,
  input logic              reg_ack,
  input logic              reg_err,
  input logic [MEM_AW-1:0] mem_addr,
  input logic              mem_lock,
  input logic              mem_rd_req,
  input logic              mem_rd_valid,
  input logic              mem_wr_req,
  input logic              mem_wr_ack,
  input logic              wr_accept,
  input logic              busy
);
  localparam int HI_IN_WORD = MEM_AW - (ADDR_W - LO_W);

  AST_START_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> (mem_rd_req && busy)); // R1
  AST_FLAG_DROPS_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_req && mem_wr_ack) |=> !busy); // R2
  AST_ERR_ON_BUSY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && reg_we && reg_addr == '0 && busy) |=> (reg_ack && reg_err)); // R3
  AST_ADDR_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mem_addr)); // R3
  AST_FIXED_HIGH_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    mem_addr[MEM_AW-1:HI_IN_WORD] == RESET_VAL[ADDR_W-1:LO_W]); // R4
  AST_NO_DUAL_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_req && mem_wr_req)); // R7
  AST_WRITE_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_wr_req) |-> $past(mem_rd_req && mem_rd_valid)); // R7
  AST_LOCK_COVERS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req || mem_wr_req) |-> mem_lock); // R8
  AST_LOCK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_req && mem_wr_ack) |=> !mem_lock); // R8
  AST_ACK_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req |=> reg_ack); // R9
  AST_READ_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && !reg_we) |=> !reg_err); // R9
endmodule

bind rmw_refresh_ctl rfr_checks #(
  .REG_AW(REG_AW), .ADDR_W(ADDR_W), .LO_W(LO_W), .MEM_AW(MEM_AW), .RESET_VAL(RESET_VAL)
) u_rfr_checks (
  .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_ack(reg_ack), .reg_err(reg_err), .mem_addr(mem_addr), .mem_lock(mem_lock),
  .mem_rd_req(mem_rd_req), .mem_rd_valid(mem_rd_valid), .mem_wr_req(mem_wr_req),
  .mem_wr_ack(mem_wr_ack), .wr_accept(wr_accept), .busy(busy)
);

// File: tb/rmw_refresh_ctl_bench.sv
`timescale 1ns/1ps
module rmw_refresh_ctl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_req = 1'b0, reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_ack, reg_err;
  logic [31:0] reg_rdata;
  logic [28:0] mem_addr;
  logic        mem_lock, mem_rd_req, mem_wr_req;
  logic        mem_rd_valid = 1'b0, mem_wr_ack = 1'b0;
  logic [63:0] mem_rd_data = '0;
  logic [63:0] mem_wdata;

  always #2 clk = ~clk;

  rmw_refresh_ctl u_rmw_refresh_ctl (
    .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_ack(reg_ack), .reg_err(reg_err), .reg_rdata(reg_rdata),
    .mem_addr(mem_addr), .mem_lock(mem_lock), .mem_rd_req(mem_rd_req),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data), .mem_wr_req(mem_wr_req),
    .mem_wdata(mem_wdata), .mem_wr_ack(mem_wr_ack)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  int rd_lat = 0, wr_lat = 0, rd_cnt = 0, wr_cnt = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] pattern(input logic [28:0] w);
    return {32'hC3A5_0000 ^ {3'b000, w}, ~{3'b000, w}};
  endfunction

  // behavioural reference model: 0 idle, 1 reading, 2 writing back
  int          m_st = 0;
  logic [15:0] m_lo = 16'h0000;
  logic [63:0] m_data = '0;
  logic        m_ack = 0, m_err = 0;
  logic [31:0] m_rdata = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_lo = 16'h0000; m_data = '0; m_ack = 0; m_err = 0; m_rdata = '0;
    end else begin
      bit pend;
      pend    = (m_st != 0);
      m_ack   = reg_req;
      m_err   = reg_req && reg_we && reg_addr == 4'h0 && pend;
      m_rdata = '0;
      if (reg_req && !reg_we) begin
        if (reg_addr == 4'h0)      m_rdata = {16'h2008, m_lo};
        else if (reg_addr == 4'h4) m_rdata = pend ? 32'd1 : 32'd0;
      end
      case (m_st)
        0: if (reg_req && reg_we && reg_addr == 4'h0) begin m_lo = reg_wdata[15:0]; m_st = 1; end
        1: if (mem_rd_valid) begin m_data = mem_rd_data; m_st = 2; end
        2: if (mem_wr_ack) m_st = 0;
        default: m_st = 0;
      endcase
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) if (rst_n) begin
    logic [31:0] full;
    full = {16'h2008, m_lo};
    chk(reg_ack == m_ack, "R9", "reg_ack", reg_ack, m_ack);
    chk(reg_err == m_err, "R3", "reg_err", reg_err, m_err);
    chk(reg_rdata == m_rdata, "R2", "reg_rdata", reg_rdata, m_rdata);
    chk(mem_rd_req == (m_st == 1), "R7", "mem_rd_req", mem_rd_req, m_st == 1);
    chk(mem_wr_req == (m_st == 2), "R7", "mem_wr_req", mem_wr_req, m_st == 2);
    chk(mem_lock == (m_st != 0), "R8", "mem_lock", mem_lock, m_st != 0);
    chk(mem_addr == full[31:3], "R5", "mem_addr", mem_addr, full[31:3]);
    if (m_st == 2) chk(mem_wdata == m_data, "R7", "mem_wdata", mem_wdata, m_data);
  end

  // memory responder with programmable latency
  always @(negedge clk) begin
    if (mem_rd_req) begin
      mem_rd_valid = (rd_cnt >= rd_lat);
      mem_rd_data  = pattern(mem_addr);
      rd_cnt++;
    end else begin
      mem_rd_valid = 1'b0; rd_cnt = 0;
    end
    if (mem_wr_req) begin
      mem_wr_ack = (wr_cnt >= wr_lat);
      if (mem_wr_ack)
        chk(mem_wdata == pattern(mem_addr), "R7", "write-back data", mem_wdata, pattern(mem_addr));
      wr_cnt++;
    end else begin
      mem_wr_ack = 1'b0; wr_cnt = 0;
    end
  end

  task automatic summary_and_end();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 20000", cyc);
      summary_and_end();
    end
  end

  // caller stands at negedge+1; returns after the acknowledge cycle
  task automatic bus(input bit we, input logic [3:0] a, input logic [31:0] d,
                     output logic [31:0] rd, output logic e);
    reg_req = 1; reg_we = we; reg_addr = a; reg_wdata = d;
    @(negedge clk); #1;
    reg_req = 0; reg_we = 0;
    rd = reg_rdata; e = reg_err;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 100 && mem_lock; i++) begin @(negedge clk); #1; end
  endtask

  initial begin
    logic [31:0] rd;
    logic e;
    repeat (3) @(negedge clk);
    chk(mem_lock == 0 && mem_rd_req == 0 && mem_wr_req == 0, "R6", "strobes in reset", {mem_lock, mem_rd_req, mem_wr_req}, 0);
    rst_n = 1;
    @(negedge clk); #1;
    bus(0, 4'h0, 0, rd, e); chk(rd == 32'h2008_0000, "R6", "reset address", rd, 32'h2008_0000);
    bus(0, 4'h4, 0, rd, e); chk(rd == 0, "R6", "reset status", rd, 0);

    // accepted write, high half ignored, low bits kept
    rd_lat = 2; wr_lat = 1;
    bus(1, 4'h0, 32'hFFFF_ABCF, rd, e); chk(e == 0, "R1", "accepted write err", e, 0);
    chk(mem_rd_req == 1 && mem_lock == 1, "R1", "read starts", {mem_rd_req, mem_lock}, 2'b11);
    chk(mem_addr == 29'({16'h2008, 16'hABCF} >> 3), "R5", "aligned word", mem_addr, 29'({16'h2008, 16'hABCF} >> 3));
    bus(0, 4'h4, 0, rd, e); chk(rd == 1 && e == 0, "R2", "status while pending", {rd[0], e}, 2'b10);
    bus(1, 4'h0, 32'h0000_1111, rd, e); chk(e == 1, "R3", "busy write err", e, 1);
    bus(0, 4'h0, 0, rd, e); chk(rd == 32'h2008_ABCF && e == 0, "R3", "value kept, read no err", rd, 32'h2008_ABCF);
    wait_idle();
    bus(0, 4'h4, 0, rd, e); chk(rd == 0, "R2", "status cleared", rd, 0);
    bus(0, 4'h0, 0, rd, e); chk(rd == 32'h2008_ABCF, "R4", "high half fixed", rd, 32'h2008_ABCF);

    // writes to status and unmapped offsets
    bus(1, 4'h4, 32'hFFFF_FFFF, rd, e); chk(e == 0 && mem_lock == 0, "R9", "status write ignored", {e, mem_lock}, 0);
    bus(1, 4'hC, 32'h0000_5555, rd, e); chk(e == 0, "R9", "unmapped write no err", e, 0);
    bus(0, 4'hC, 0, rd, e); chk(rd == 0, "R9", "unmapped read", rd, 0);
    bus(0, 4'h0, 0, rd, e); chk(rd == 32'h2008_ABCF, "R9", "register untouched", rd, 32'h2008_ABCF);

    // zero-latency memory
    rd_lat = 0; wr_lat = 0;
    bus(1, 4'h0, 32'h0000_0007, rd, e); chk(e == 0, "R1", "zero-latency start", e, 0);
    wait_idle();
    bus(0, 4'h0, 0, rd, e); chk(rd == 32'h2008_0007, "R5", "low bits read back", rd, 32'h2008_0007);

    // write in the acknowledge cycle
    rd_lat = 1; wr_lat = 3;
    bus(1, 4'h0, 32'h0000_2468, rd, e);
    for (int i = 0; i < 50 && !mem_wr_ack; i++) begin @(negedge clk); #1; end
    chk(mem_wr_ack == 1, "R10", "ack reached", mem_wr_ack, 1);
    bus(1, 4'h0, 32'h0000_1357, rd, e); chk(e == 1, "R10", "write at ack refused", e, 1);
    chk(mem_lock == 0, "R8", "lock released", mem_lock, 0);
    bus(0, 4'h0, 0, rd, e); chk(rd == 32'h2008_2468, "R10", "value kept", rd, 32'h2008_2468);
    bus(1, 4'h0, 32'h0000_1357, rd, e); chk(e == 0, "R10", "next write accepted", e, 0);
    wait_idle();
    repeat (2) @(negedge clk);
    summary_and_end();
  end
endmodule